// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a memory burst of four beats. A burst is opened by one of two active-low address-status strobes, one meant for a processor and one for a cache controller. On that clock edge the full presented address is captured: the upper bits stay frozen for the rest of the burst, and the two lowest bits seed a 2-bit beat counter. Each later clock edge with the active-low advance input asserted moves the burst to its next beat. Edges with no strobe and no advance leave the address unchanged.

A static order pin chooses how the low two bits move through the burst. With the pin low the order is linear: the offset is the start offset plus the beat number, modulo four. With the pin high the order is interleaved: the offset is the start offset XOR the beat number. After the fourth beat the counter wraps to the first beat's offset. The upper bits are never incremented. A new strobe always wins over advance and restarts the burst from the new address. The processor strobe is qualified only by the primary active-low enable. The controller strobe needs all three enables active.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is zero and `beat_o` is zero.
- R2: When `ads_proc_n` is low and `en_n` is low at a rising edge, `addr_o` equals `addr_i` and `beat_o` is 0 after that edge, whatever `en_hi` and `en2_n` are.
- R3: When `ads_ctrl_n` is low at a rising edge, a load as in R2 takes place only if `en_n` is low, `en_hi` is high and `en2_n` is low; otherwise the strobe has no effect.
- R4: When `en_n` is high, `ads_proc_n` low has no effect, and the edge behaves as if no strobe were present.
- R5: When no load occurs and `adv_n` is low at a rising edge, `beat_o` increments by one modulo 4.
- R6: When `order_i` is 0 (linear), `addr_o[1:0]` equals (start offset + `beat_o`) mod 4. The start offset is `addr_i[1:0]` captured at the load.
- R7: When `order_i` is 1 (interleaved), `addr_o[1:0]` equals start offset XOR `beat_o`.
- R8: An advance from beat 3 returns to beat 0 and the start offset. `addr_o` bits above bit 1 never change without a load.
- R9: A valid strobe together with `adv_n` low performs the load and ignores the advance.
- R10: When no load occurs and `adv_n` is high, `addr_o` and `beat_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Presented word address |
| ads_proc_n | input | 1 | Processor address-status strobe, active low |
| ads_ctrl_n | input | 1 | Controller address-status strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| en_n | input | 1 | Primary enable, active low |
| en_hi | input | 1 | Secondary enable, active high |
| en2_n | input | 1 | Tertiary enable, active low |
| addr_o | output | ADDR_W | Current burst word address |
| beat_o | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The embedded assertions check on every cycle that a load clears the beat index, that an advance steps it by exactly one, and that an idle edge holds it. They also check that the upper address bits stay frozen between loads and that a disabled primary enable blocks every load. The bench's scenarios are what show the actual offset orders in both modes and the wrap back to the start offset. They also show the full enable qualification of the controller strobe, and that a strobe wins over advance with the newly presented address.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Linear order: start offset plus beat, wrapping inside the 4-beat window
  function automatic logic [1:0] lin_off(input logic [1:0] start, input logic [1:0] beat);
    return start + beat;
  endfunction

  // Interleaved order: start offset toggled by the beat number
  function automatic logic [1:0] ilv_off(input logic [1:0] start, input logic [1:0] beat);
    return start ^ beat;
  endfunction

  function automatic logic [1:0] burst_off(input logic ilv, input logic [1:0] start,
                                           input logic [1:0] beat);
    return ilv ? ilv_off(start, beat) : lin_off(start, beat);
  endfunction

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic adv_n,
  input  logic en_n,
  input  logic en_hi,
  input  logic en2_n,
  output logic load_o,
  output logic step_o
);

  logic proc_ok;
  logic ctrl_ok;

  assign proc_ok = !ads_proc_n && !en_n;
  assign ctrl_ok = !ads_ctrl_n && !en_n && en_hi && !en2_n;
  assign load_o  = proc_ok || ctrl_ok;
  assign step_o  = !load_o && !adv_n;

  AST_NO_LOAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !load_o); // R4

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !step_o); // R9

endmodule

// File: rtl/burst_counter.sv
module burst_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       step_i,
  input  logic [1:0] seed_i,
  output logic [1:0] start_o,
  output logic [1:0] beat_o
);

  logic [1:0] start_q;
  logic [1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 2'd0;
      beat_q  <= 2'd0;
    end else if (load_i) begin
      start_q <= seed_i;
      beat_q  <= 2'd0;
    end else if (step_i) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;

  AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == 2'd0)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (beat_o == $past(beat_o) + 2'd1)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(beat_o) && $stable(start_o))); // R10

  AST_START_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(start_o)); // R8

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              order_i,
  input  logic              en_n,
  input  logic              en_hi,
  input  logic              en2_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);

  import burst_pkg::*;

  localparam int UP_W = ADDR_W - 2;

  logic            load;
  logic            step;
  logic [1:0]      start;
  logic [1:0]      beat;
  logic [UP_W-1:0] upper_q;

  burst_load_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .en_n       (en_n),
    .en_hi      (en_hi),
    .en2_n      (en2_n),
    .load_o     (load),
    .step_o     (step)
  );

  burst_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .seed_i  (addr_i[1:0]),
    .start_o (start),
    .beat_o  (beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    upper_q <= '0;
    else if (load) upper_q <= addr_i[ADDR_W-1:2];
  end

  assign addr_o = {upper_q, burst_off(order_i, start, beat)};
  assign beat_o = beat;

  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_o[ADDR_W-1:2])); // R8

  AST_OFF_DISABLED_HOLDS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(addr_o[ADDR_W-1:2])); // R4

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_o == $past(addr_i))); // R2

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
  logic          order_i = 1'b0, en_n = 1'b0, en_hi = 1'b1, en2_n = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .order_i(order_i), .en_n(en_n),
    .en_hi(en_hi), .en2_n(en2_n), .addr_o(addr_o), .beat_o(beat_o)
  );

  // scoreboard
  logic [AW+1:0] exp_q[$];
  string         tag_q[$];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 0;

  // independent reference state
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_st = '0;
  logic [1:0]    m_bt = '0;

  task automatic check(input logic [AW+1:0] got, input logic [AW+1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: addr/beat got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic pn, input logic cn, input logic an, input logic md,
                     input logic e0n, input logic e1, input logic e2n,
                     input logic [AW-1:0] a, input string tag);
    logic ld;
    logic [1:0] off;
    @(negedge clk);
    ads_proc_n = pn; ads_ctrl_n = cn; adv_n = an; order_i = md;
    en_n = e0n; en_hi = e1; en2_n = e2n; addr_i = a;
    ld = (!pn && !e0n) || (!cn && !e0n && e1 && !e2n);
    if (ld) begin
      m_up = a[AW-1:2]; m_st = a[1:0]; m_bt = 2'd0;
    end else if (!an) begin
      m_bt = (m_bt == 2'd3) ? 2'd0 : m_bt + 2'd1;
    end
    if (md) off = {m_st[1] ^ m_bt[1], m_st[0] ^ m_bt[0]};
    else    off = 2'((int'(m_st) + int'(m_bt)) % 4);
    exp_q.push_back({m_up, off, m_bt});
    tag_q.push_back(tag);
  endtask

  // monitor: one item per clock edge, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW+1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({addr_o, beat_o}, e, t);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #7;
    check({addr_o, beat_o}, '0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(1,1,1,0, 0,1,0, 18'h3FFFF, "R1 idle after reset");
    // proc load with other enables off: still loads
    cyc(0,1,1,0, 0,0,1, 18'h12345, "R2 proc load");
    cyc(1,1,0,0, 0,1,0, 18'h00000, "R5 R6 linear beat1");
    cyc(1,1,0,0, 0,1,0, 18'h00000, "R6 linear beat2");
    cyc(1,1,0,0, 0,1,0, 18'h00000, "R6 linear beat3");
    cyc(1,1,0,0, 0,1,0, 18'h3FFFF, "R8 wrap to start");
    cyc(1,1,1,0, 0,1,0, 18'h2AAAA, "R10 hold");
    cyc(1,1,1,0, 0,1,0, 18'h15555, "R10 hold again");
    // interleaved from offset 2
    cyc(0,1,1,1, 0,1,0, 18'h0ABC2, "R7 ilv load");
    cyc(1,1,0,1, 0,1,0, 18'h00000, "R7 ilv beat1");
    cyc(1,1,0,1, 0,1,0, 18'h00000, "R7 ilv beat2");
    cyc(1,1,0,1, 0,1,0, 18'h00000, "R7 ilv beat3");
    cyc(1,1,0,1, 0,1,0, 18'h00000, "R8 ilv wrap");
    cyc(1,1,1,0, 0,1,0, 18'h00000, "R6 order pin switch");
    // controller strobe qualification
    cyc(1,0,1,0, 0,1,0, 18'h30001, "R3 ctrl load");
    cyc(1,0,1,0, 0,0,0, 18'h05553, "R3 ctrl ignored en_hi low");
    cyc(1,0,1,0, 0,1,1, 18'h05553, "R3 ctrl ignored en2_n high");
    cyc(1,0,0,0, 1,1,0, 18'h05553, "R3 ctrl ignored en_n high, advance");
    // processor strobe gated by primary enable
    cyc(0,1,1,0, 1,1,0, 18'h1FFFF, "R4 proc ignored, hold");
    cyc(0,1,0,0, 1,0,1, 18'h1FFFF, "R4 proc ignored, advance");
    // priority of strobe over advance
    cyc(0,1,0,1, 0,1,0, 18'h2468B, "R9 strobe beats advance");
    cyc(1,0,0,1, 0,1,0, 18'h13579, "R9 ctrl strobe beats advance");
    cyc(1,1,0,1, 0,1,0, 18'h00000, "R7 R5 ilv from 1");
    cyc(1,1,1,1, 0,1,0, 18'h00000, "R10 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule